// File: doc/BRIEF.md
# Fast Link Pulse Burst Generator

This block produces the auto-negotiation pulse bursts for one Ethernet port while its link is down. Each burst has 33 evenly spaced pulse slots. Slots at the odd positions (first, third, up to the thirty-third) always carry a timing pulse. The sixteen slots between them carry the bits of a 16-bit link code word: a pulse means a one and no pulse means a zero. Bursts repeat at a fixed interval. While `enable` is high, one burst starts at the top of every interval. When the link comes up, the surrounding logic lowers `enable`, the output goes quiet and the timebase is cleared.

All timing is given in clock cycles by parameters: the slot spacing (62.5 µs by default), the burst repetition interval (16 ms, measured from the start of one burst to the start of the next) and the pulse width (about 100 ns). The defaults assume a 250 MHz clock. The code word is captured only at the start of a burst, so a caller can load the next page's word while a burst is still being sent. A one-cycle strobe marks the cycle that follows the last slot.

Top module: `flp_burst_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pulse_out` and `burst_done` are 0 after that edge, whatever the value of `enable`.
- R2: While `enable` is low, `pulse_out` and `burst_done` stay 0, starting from the cycle after the first edge that samples `enable` low.
- R3: The first edge that samples `enable` high (after reset, or after a low period) starts a burst. Call the cycle after that edge burst cycle 0. `pulse_out` is 1 in burst cycle 0.
- R4: A burst has 33 slots numbered 0 to 32, each `SLOT_CYCLES` long. Slot s covers burst cycles s*SLOT_CYCLES to s*SLOT_CYCLES+SLOT_CYCLES-1. A pulse fills only the first `PULSE_CYCLES` cycles of its slot. `pulse_out` is 0 in every other cycle.
- R5: Slots with an even number (0, 2, ..., 32) always carry a pulse.
- R6: Slot 2k+1 carries a pulse exactly when bit k of the captured code word is 1, for k = 0 to 15. The least-significant bit is sent first.
- R7: The code word is sampled only at the edge that starts a burst. Changing `code_word` during a burst does not change the data slots of that burst.
- R8: `burst_done` is 1 for exactly one cycle per burst, in burst cycle 33*SLOT_CYCLES. `pulse_out` is 0 in that cycle.
- R9: While `enable` stays high, a new burst starts every `PERIOD_CYCLES` cycles. Each new burst uses the `code_word` value present at its own start.
- R10: Lowering `enable` in the middle of a burst stops the output from the next cycle. When `enable` is raised again, a complete new burst starts from slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the whole timebase |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | High while the link is down and bursts are wanted |
| code_word | input | 16 | Link code word, sampled at each burst start |
| pulse_out | output | 1 | Pulse train to the line driver |
| burst_done | output | 1 | One-cycle strobe after the last slot of a burst |

## Verification
Both outputs are registered once after the combinational slot decode. So the result for burst cycle n appears right after the n-th edge counted from the edge that first sees `enable` high (that first edge is edge 0). The bench drives inputs on falling edges. It compares both outputs against a model of slot, offset and code word on every falling edge, which is half a cycle after each result becomes due. A lowered `enable` and a changed `code_word` take effect at the next rising edge. The expected outputs therefore switch one sample after the falling edge on which the stimulus was applied.

// File: rtl/flp_pkg.sv
// Shared constants and types for the fast link pulse burst generator.
// Assumes a fixed burst layout of 33 slots carrying a 16-bit word.
package flp_pkg;
    localparam int unsigned FLP_SLOTS   = 33;
    localparam int unsigned FLP_WORD_W  = 16;
    localparam int unsigned FLP_IDX_W   = 6;

    typedef logic [FLP_IDX_W-1:0]  slot_idx_t;
    typedef logic [FLP_WORD_W-1:0] code_word_t;
endpackage

// File: rtl/flp_timebase.sv
// Free-running burst timebase. Counts the repetition period and, within
// the burst part of it, the slot index and the offset inside the slot.
// Assumes SLOT_CYCLES >= 2 and PERIOD_CYCLES > 33*SLOT_CYCLES.
module flp_timebase
    import flp_pkg::*;
#(
    parameter int unsigned SLOT_CYCLES   = 15625,
    parameter int unsigned PERIOD_CYCLES = 4000000,
    localparam int unsigned SLOT_W       = $clog2(SLOT_CYCLES),
    localparam int unsigned PER_W        = $clog2(PERIOD_CYCLES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    output logic              burst_start,
    output logic              burst_end,
    output logic              in_burst,
    output slot_idx_t         slot_idx,
    output logic [SLOT_W-1:0] slot_cyc
);
    localparam int unsigned BURST_LEN = FLP_SLOTS * SLOT_CYCLES;
    localparam logic [PER_W-1:0]  PER_LAST  = PER_W'(PERIOD_CYCLES - 1);
    localparam logic [PER_W-1:0]  PER_END   = PER_W'(BURST_LEN);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_CYCLES - 1);

    logic [PER_W-1:0] per_cnt;

    // Decode burst framing from the counters.
    always_comb begin
        in_burst    = (slot_idx < slot_idx_t'(FLP_SLOTS));
        burst_start = enable && (per_cnt == '0);
        burst_end   = enable && (per_cnt == PER_END);
    end

    // Advance period, slot and offset counters; clear them while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            per_cnt  <= '0;
            slot_idx <= '0;
            slot_cyc <= '0;
        end else if (per_cnt == PER_LAST) begin
            per_cnt  <= '0;
            slot_idx <= '0;
            slot_cyc <= '0;
        end else begin
            per_cnt <= per_cnt + 1'b1;
            if (in_burst) begin
                if (slot_cyc == SLOT_LAST) begin
                    slot_cyc <= '0;
                    slot_idx <= slot_idx + 1'b1;
                end else begin
                    slot_cyc <= slot_cyc + 1'b1;
                end
            end
        end
    end

    // R4: the slot index never runs past the gap marker.
    p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        slot_idx <= slot_idx_t'(FLP_SLOTS));

    // R4: the offset inside a slot stays within the slot length.
    p_cyc_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        slot_cyc <= SLOT_LAST);

    // R3: a rising enable always lands on a burst start.
    p_start_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |-> burst_start);

    // R9: in the gap between bursts the slot offset rests at zero.
    p_gap_rest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_burst |-> (slot_cyc == '0));
endmodule

// File: rtl/flp_pulse_map.sv
// Maps slot position to a pulse request. Captures the code word at each
// burst start; even slots are timing pulses, odd slot 2k+1 carries bit k.
// Assumes PULSE_CYCLES < SLOT_CYCLES.
module flp_pulse_map
    import flp_pkg::*;
#(
    parameter int unsigned SLOT_W       = 14,
    parameter int unsigned PULSE_CYCLES = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_start,
    input  logic              in_burst,
    input  code_word_t        code_word,
    input  slot_idx_t         slot_idx,
    input  logic [SLOT_W-1:0] slot_cyc,
    output logic              pulse_req
);
    code_word_t word_q;
    logic       in_window;
    logic       slot_has_pulse;

    // Capture the code word only when a burst begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (burst_start) begin
            word_q <= code_word;
        end
    end

    // Pulse window inside the slot: single-cycle or wider variant.
    generate
        if (PULSE_CYCLES == 1) begin : g_narrow
            assign in_window = (slot_cyc == '0);
        end else begin : g_wide
            assign in_window = (slot_cyc < SLOT_W'(PULSE_CYCLES));
        end
    endgenerate

    // Clock slots always pulse; data slots follow the captured word.
    always_comb begin
        slot_has_pulse = !slot_idx[0] || word_q[slot_idx[4:1]];
        pulse_req      = in_burst && in_window && slot_has_pulse;
    end

    // R7: the captured word changes only right after a burst start.
    p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(burst_start) |-> $stable(word_q));

    // R5: a clock slot inside its pulse window always requests a pulse.
    p_clock_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_burst && !slot_idx[0] && slot_cyc == '0) |-> pulse_req);
endmodule

// File: rtl/flp_burst_gen.sv
// Top of the fast link pulse burst generator for one port. Combines the
// timebase and the pulse map and registers both outputs once.
// Assumes defaults for a 250 MHz clock: 62.5 us slots, 16 ms period,
// roughly 100 ns pulses.
module flp_burst_gen
    import flp_pkg::*;
#(
    parameter int unsigned SLOT_CYCLES   = 15625,
    parameter int unsigned PERIOD_CYCLES = 4000000,
    parameter int unsigned PULSE_CYCLES  = 25,
    localparam int unsigned SLOT_W       = $clog2(SLOT_CYCLES)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic [15:0] code_word,
    output logic        pulse_out,
    output logic        burst_done
);
    logic              burst_start;
    logic              burst_end;
    logic              in_burst;
    slot_idx_t         slot_idx;
    logic [SLOT_W-1:0] slot_cyc;
    logic              pulse_req;

    flp_timebase #(
        .SLOT_CYCLES   (SLOT_CYCLES),
        .PERIOD_CYCLES (PERIOD_CYCLES)
    ) u_timebase (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .burst_start (burst_start),
        .burst_end   (burst_end),
        .in_burst    (in_burst),
        .slot_idx    (slot_idx),
        .slot_cyc    (slot_cyc)
    );

    flp_pulse_map #(
        .SLOT_W       (SLOT_W),
        .PULSE_CYCLES (PULSE_CYCLES)
    ) u_pulse_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .burst_start (burst_start),
        .in_burst    (in_burst),
        .code_word   (code_word),
        .slot_idx    (slot_idx),
        .slot_cyc    (slot_cyc),
        .pulse_req   (pulse_req)
    );

    // Register the line pulse and the end-of-burst strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_out  <= 1'b0;
            burst_done <= 1'b0;
        end else begin
            pulse_out  <= enable && pulse_req;
            burst_done <= enable && burst_end;
        end
    end

    // R2: a low enable silences both outputs from the next cycle.
    p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!pulse_out && !burst_done));

    // R8: the done strobe lasts a single cycle.
    p_done_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> !burst_done);

    // R8: the done strobe never coincides with a pulse.
    p_done_no_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> !pulse_out);
endmodule

// File: tb/sim_flp_burst_gen.sv
`timescale 1ns/1ps
module sim_flp_burst_gen;
    localparam int SLOT   = 8;
    localparam int PULSE  = 3;
    localparam int PERIOD = 300;
    localparam int BLEN   = 33 * SLOT;
    localparam int NVEC   = 6;

    // {code word, expected pulses per burst = 17 + ones in word}
    localparam logic [31:0] VEC [NVEC] = '{
        {16'h0000, 16'd17},
        {16'hFFFF, 16'd33},
        {16'hA5C3, 16'd25},
        {16'h8001, 16'd19},
        {16'h1234, 16'd22},
        {16'h0001, 16'd18}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] code_word = '0;
    logic        pulse_out;
    logic        burst_done;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    flp_burst_gen #(
        .SLOT_CYCLES   (SLOT),
        .PERIOD_CYCLES (PERIOD),
        .PULSE_CYCLES  (PULSE)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .code_word  (code_word),
        .pulse_out  (pulse_out),
        .burst_done (burst_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic exp_pulse(input logic [15:0] w, input int n);
        int m = n % PERIOD;
        int s = m / SLOT;
        int c = m % SLOT;
        if (m >= BLEN || c >= PULSE) return 1'b0;
        if (s % 2 == 0) return 1'b1;
        return w[s / 2];
    endfunction

    // Scan from a burst start: word wa for the first burst, wb afterwards;
    // code_word is switched to wb on the falling edge of cycle change_at.
    task automatic scan(input logic [15:0] wa, input logic [15:0] wb,
                        input int change_at, input int ncyc, input string req);
        int bad_p = -1, bad_d = -1, act_p = 0, act_d = 0, pcnt = 0, dcnt = 0;
        logic prev = 1'b0;
        code_word = wa;
        enable    = 1'b1;
        for (int n = 0; n < ncyc; n++) begin
            logic ep, ed;
            @(negedge clk);
            ep = exp_pulse((n < PERIOD) ? wa : wb, n);
            ed = ((n % PERIOD) == BLEN);
            if (pulse_out !== ep && bad_p < 0) begin bad_p = n; act_p = pulse_out; end
            if (burst_done !== ed && bad_d < 0) begin bad_d = n; act_d = burst_done; end
            if (pulse_out && !prev && n < PERIOD) pcnt++;
            if (burst_done && n < PERIOD) dcnt++;
            prev = pulse_out;
            if (n == change_at) code_word = wb;
        end
        check(bad_p < 0, req, $sformatf("pulse pattern word %h first bad cycle %0d", wa, bad_p),
              act_p, bad_p < 0 ? act_p : int'(exp_pulse((bad_p < PERIOD) ? wa : wb, bad_p)));
        check(bad_d < 0, req, $sformatf("done strobe first bad cycle %0d", bad_d),
              act_d, bad_d < 0 ? act_d : int'((bad_d % PERIOD) == BLEN));
        if (ncyc >= PERIOD)
            check(dcnt == 1, "R8", "done strobes in first burst", dcnt, 1);
        n_tests = n_tests;
        if (ncyc >= BLEN) begin
            int ones = 17 + $countones(wa);
            check(pcnt == ones, "R6", "pulses in first burst", pcnt, ones);
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        // R1: reset dominates even with enable high.
        enable = 1'b1;
        code_word = 16'hFFFF;
        repeat (3) @(negedge clk);
        check(pulse_out == 1'b0 && burst_done == 1'b0, "R1", "outputs in reset",
              {pulse_out, burst_done}, 0);
        enable = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R2: idle with enable low.
        begin
            int busy = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (pulse_out || burst_done) busy++;
            end
            check(busy == 0, "R2", "active cycles while disabled", busy, 0);
        end

        // R3 R4 R5 R6 R8: table of code words, each a fresh burst.
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] w  = VEC[v][31:16];
            int          ex = int'(VEC[v][15:0]);
            enable = 1'b0;
            repeat (2) @(negedge clk);
            check(!pulse_out && !burst_done, "R2", "quiet before burst", pulse_out, 0);
            check(ex == 17 + $countones(w), "R6", "table pulse count entry", ex, 17 + $countones(w));
            scan(w, w, -1, PERIOD, "R4");
        end

        // R7 R9: mid-burst word change ignored; next burst picks it up.
        enable = 1'b0;
        repeat (2) @(negedge clk);
        scan(16'h00FF, 16'hF00F, 100, 2 * PERIOD, "R7");
        // a further period confirming R9 repetition with the new word
        begin
            int bad = 0;
            for (int n = 2 * PERIOD; n < 3 * PERIOD; n++) begin
                @(negedge clk);
                if (pulse_out !== exp_pulse(16'hF00F, n)) bad++;
            end
            check(bad == 0, "R9", "third burst mismatched cycles", bad, 0);
        end

        // R10: drop enable mid-burst, then restart from slot 0.
        enable = 1'b0;
        repeat (2) @(negedge clk);
        scan(16'hFFFF, 16'hFFFF, -1, 101, "R10");
        enable = 1'b0;
        begin
            int busy = 0;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if (pulse_out || burst_done) busy++;
            end
            check(busy == 0, "R10", "active cycles after drop", busy, 0);
        end
        scan(16'h0F0F, 16'h0F0F, -1, PERIOD, "R10");

        // R3: pulse present in the very first burst cycle.
        enable = 1'b0;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        code_word = 16'h0000;
        @(negedge clk);
        check(pulse_out == 1'b1, "R3", "first burst cycle pulse", pulse_out, 1);
        repeat (PULSE) @(negedge clk);
        check(pulse_out == 1'b0, "R4", "pulse ended after width", pulse_out, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule